// File: doc/BRIEF.md
# Timeout Watchdog with Two-Stage Escalation and Boot-Failure Detection

This block is a software-serviced watchdog. A small down-counter is decremented on every timebase tick; firmware is expected to reload it before it runs out. When the counter reaches zero and is ticked again, that is a timeout: the first one raises a status flag (and, if enabled, an interrupt) and the count restarts from the reload value. If a second timeout arrives while the first flag is still standing, a second flag is raised and a full system reset is requested unless software has set a no-reboot control.

The block also detects a machine that never reached its boot ROM. A flag remembers whether a ROM fetch strobe has been seen since the last PCI reset. If the second-timeout flag goes from 0 to 1 while no such fetch has been seen, a boot-failure flag is set. That flag is kept through PCI resets and cleared only by the power-well reset or by software.

Software uses a four-word register port with a combinational read path. The reset sequencer that acts on the request output is a separate block.

Top module: `tco_watchdog`

## Requirements
- R1: After `rst_n` is low at a clock edge, the count (address 0) and the reload value (address 1) read the parameter `RELOAD_RST`, the control word (address 2) and the status word (address 3) read 0, and `irq` and `rst_req` are low.
- R2: On each clock edge with `tick` high, halt clear, no count write and a nonzero count, the count read at address 0 (bits 5:0) drops by one.
- R3: A write of any data to address 0 loads the count from the reload register (address 1, bits 5:0). This load takes priority over a tick in the same cycle.
- R4: A tick with the count at zero, halt clear and status bit 0 clear sets status bit 0 (first timeout) and loads the count from the reload register. `irq` is high exactly while status bit 0 and control bit 2 (interrupt enable) are both set.
- R5: A tick with the count at zero while status bit 0 is already set sets status bit 1 (second timeout) and again loads the count from the reload register.
- R6: `rst_req` is high exactly while status bit 1 is set and control bit 1 (no-reboot) is clear.
- R7: While control bit 0 (halt) is set, ticks leave the count and the timeout flags unchanged.
- R8: Status bit 2 (boot failure) is set when status bit 1 changes from 0 to 1 and no `rom_access` pulse has occurred since the last PCI or power-well reset.
- R9: Writing to address 3 clears each status bit that is written as 1. A bit being set in the same cycle stays set.
- R10: With `rst_n` high and `pci_rst_n` low at an edge, everything returns to the R1 state except status bit 2, which keeps its value. The ROM-seen record is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-well synchronous reset, active low; clears all state |
| pci_rst_n | input | 1 | PCI synchronous reset, active low; clears all but the boot-failure flag |
| tick | input | 1 | Timebase strobe, one decrement per high cycle |
| rom_access | input | 1 | Pulse on each boot-ROM fetch |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 count, 1 reload, 2 control, 3 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | First-timeout interrupt |
| rst_req | output | 1 | Full-reset request |

## Verification
The bench drives a timeout while status bit 0 is set and checks that this is escalated. A design that counts timeouts in its own counter, instead of testing the standing first flag, would escalate after software had already acknowledged the first timeout. A ROM fetch placed before the escalation must suppress boot failure, and one placed before a PCI reset must not. A tracker that is not cleared by PCI reset would then miss a hung reboot, and a boot flag that is cleared by PCI reset would lose the evidence. Count writes in the same cycle as a tick, status clears in the same cycle as a timeout, and reload values of 0 are all exercised, because each of them exposes a wrong priority or an off-by-one in the expiry tick.

// File: rtl/tco_pkg.sv
// Package: register map constants and the control word layout shared by
// the register, counter and status blocks of the timeout watchdog.
package tco_pkg;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;

    // status bit positions
    localparam int ST_FIRST  = 0;
    localparam int ST_SECOND = 1;
    localparam int ST_BOOT   = 2;
    localparam int ST_W      = 3;

    // control word, bit 0 = halt, bit 1 = no-reboot, bit 2 = irq enable
    typedef struct packed {
        logic irq_en;
        logic no_reboot;
        logic halt;
    } ctrl_t;
    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tco_regs.sv
// Register port of the watchdog. It holds the reload value and the control
// word, decodes count writes into a load pulse and status writes into a
// write-1-to-clear mask, and muxes read data. It assumes CNT_W <= DATA_W and
// that reads have no side effects.
module tco_regs
    import tco_pkg::*;
#(
    parameter int                CNT_W      = 6,
    parameter logic [CNT_W-1:0]  RELOAD_RST = 6'd10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pci_rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [ST_W-1:0]   status_i,
    output logic [CNT_W-1:0]  reload_o,
    output ctrl_t             ctrl_o,
    output logic              load_o,
    output logic [ST_W-1:0]   clr_o,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int PAD_CNT  = DATA_W - CNT_W;
    localparam int PAD_CTRL = DATA_W - CTRL_W;
    localparam int PAD_ST   = DATA_W - ST_W;

    logic [CNT_W-1:0] reload_q;
    ctrl_t            ctrl_q;

    // Write strobes decoded from the address.
    always_comb begin
        load_o = reg_wr && (reg_addr == A_COUNT);
        clr_o  = (reg_wr && (reg_addr == A_STATUS)) ? reg_wdata[ST_W-1:0] : '0;
    end

    // Reload value and control word storage; both reset on either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !pci_rst_n) begin
            reload_q <= RELOAD_RST;
            ctrl_q   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_RELOAD) reload_q <= reg_wdata[CNT_W-1:0];
            if (reg_addr == A_CTRL)   ctrl_q   <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    // Read data multiplexer.
    always_comb begin
        unique case (reg_addr)
            A_COUNT:  reg_rdata = {{PAD_CNT{1'b0}}, cnt_i};
            A_RELOAD: reg_rdata = {{PAD_CNT{1'b0}}, reload_q};
            A_CTRL:   reg_rdata = {{PAD_CTRL{1'b0}}, ctrl_q};
            default:  reg_rdata = {{PAD_ST{1'b0}}, status_i};
        endcase
    end

    assign reload_o = reload_q;
    assign ctrl_o   = ctrl_q;

    // R10: a PCI reset returns the reload value to its reset constant
    a_r10_reload_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !pci_rst_n |=> reload_q == RELOAD_RST);
endmodule

// File: rtl/tco_counter.sv
// Watchdog down-counter. It decrements on each unhalted tick, restarts from
// the reload value on the tick after zero (flagging an expiry), and loads on
// a software count write, which has priority. It assumes tick is synchronous
// to clk.
module tco_counter #(
    parameter int               CNT_W      = 6,
    parameter logic [CNT_W-1:0] RELOAD_RST = 6'd10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pci_rst_n,
    input  logic             tick_i,
    input  logic             halt_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             step;
    logic             at_zero;

    // Decode whether this cycle counts and whether the counter is spent.
    always_comb begin
        step     = tick_i && !halt_i && !load_i;
        at_zero  = (cnt_q == '0);
        expire_o = step && at_zero;
    end

    // Count register: load, decrement or restart after expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !pci_rst_n) begin
            cnt_q <= RELOAD_RST;
        end else if (load_i) begin
            cnt_q <= reload_i;
        end else if (step) begin
            cnt_q <= at_zero ? reload_i : cnt_q - 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // R2: an unhalted tick on a nonzero count takes exactly one off
    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_rst_n && tick_i && !halt_i && !load_i && cnt_q != '0)
        |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
    // R3: a count write lands the reload value
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_rst_n && load_i) |=> cnt_q == $past(reload_i));
    // R7: halt freezes the count when software does not write it
    a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_rst_n && halt_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tco_status.sv
// Timeout status flags and boot-failure tracking. An expiry sets the first
// flag, or the second if the first is still standing. A rise of the second
// flag with no ROM fetch since reset sets the boot flag, which survives PCI
// reset. All flags are write-1-to-clear, with set winning.
module tco_status
    import tco_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pci_rst_n,
    input  logic            expire_i,
    input  logic            rom_access_i,
    input  logic [ST_W-1:0] clr_i,
    output logic [ST_W-1:0] status_o
);
    logic first_q, second_q, boot_q, rom_seen_q;
    logic set_first, set_second, set_boot;

    // Classify an expiry and detect a boot that never reached the ROM.
    always_comb begin
        set_first  = expire_i && !first_q;
        set_second = expire_i && first_q;
        set_boot   = set_second && !second_q && !rom_seen_q;
    end

    // Timeout flags and ROM-seen record; cleared by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !pci_rst_n) begin
            first_q    <= 1'b0;
            second_q   <= 1'b0;
            rom_seen_q <= 1'b0;
        end else begin
            first_q    <= set_first  || (first_q  && !clr_i[ST_FIRST]);
            second_q   <= set_second || (second_q && !clr_i[ST_SECOND]);
            rom_seen_q <= rom_seen_q || rom_access_i;
        end
    end

    // Boot-failure flag; only the power-well reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q <= 1'b0;
        end else if (pci_rst_n) begin
            boot_q <= set_boot || (boot_q && !clr_i[ST_BOOT]);
        end
    end

    always_comb begin
        status_o            = '0;
        status_o[ST_FIRST]  = first_q;
        status_o[ST_SECOND] = second_q;
        status_o[ST_BOOT]   = boot_q;
    end

    // R5: the second flag only rises over a standing first flag
    a_r5_second_after_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(second_q) |-> $past(first_q));
    // R8: boot failure never rises once the ROM has been fetched
    a_r8_boot_needs_no_rom: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_q) |-> (!$past(rom_seen_q) && $rose(second_q)));
    // R10: a PCI reset leaves the boot flag alone
    a_r10_boot_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !pci_rst_n |=> $stable(boot_q));
endmodule

// File: rtl/tco_watchdog.sv
// Top of the timeout watchdog: wires the register port, down-counter and
// status logic together and forms the interrupt and reset-request outputs.
// It assumes all inputs are synchronous to clk. The request is a level that
// stays high until software clears the second flag or sets no-reboot.
module tco_watchdog
    import tco_pkg::*;
#(
    parameter int               CNT_W      = 6,
    parameter logic [CNT_W-1:0] RELOAD_RST = 6'd10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pci_rst_n,
    input  logic              tick,
    input  logic              rom_access,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              rst_req
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload;
    ctrl_t            ctrl;
    logic             load;
    logic             expire;
    logic [ST_W-1:0]  clr;
    logic [ST_W-1:0]  status;

    tco_regs #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .pci_rst_n(pci_rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .cnt_i(cnt), .status_i(status),
        .reload_o(reload), .ctrl_o(ctrl), .load_o(load), .clr_o(clr),
        .reg_rdata(reg_rdata)
    );

    tco_counter #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_counter (
        .clk(clk), .rst_n(rst_n), .pci_rst_n(pci_rst_n),
        .tick_i(tick), .halt_i(ctrl.halt), .load_i(load), .reload_i(reload),
        .cnt_o(cnt), .expire_o(expire)
    );

    tco_status u_status (
        .clk(clk), .rst_n(rst_n), .pci_rst_n(pci_rst_n),
        .expire_i(expire), .rom_access_i(rom_access), .clr_i(clr),
        .status_o(status)
    );

    // Interrupt and reset-request outputs.
    always_comb begin
        irq     = status[ST_FIRST] && ctrl.irq_en;
        rst_req = status[ST_SECOND] && !ctrl.no_reboot;
    end

    // R6: no-reboot always masks the request
    a_r6_no_reboot_masks: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.no_reboot |-> !rst_req);
    // R7: halted ticks never raise a timeout flag
    a_r7_halt_no_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_rst_n && ctrl.halt) |=> !$rose(status[ST_FIRST]) && !$rose(status[ST_SECOND]));
endmodule

// File: tb/tco_watchdog_tb.sv
`timescale 1ns/100ps
module tco_watchdog_tb;
    localparam int CNT_W = 6;
    localparam logic [CNT_W-1:0] RST_VAL = 6'd10;

    logic clk = 1'b0;
    logic rst_n = 1'b0, pci_rst_n = 1'b1, tick = 1'b0, rom_access = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic irq, rst_req;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // model state
    logic [5:0] m_cnt, m_rel;
    logic [2:0] m_ctrl, m_st;
    logic m_seen;

    always #2 clk = ~clk;

    tco_watchdog #(.CNT_W(CNT_W), .RELOAD_RST(RST_VAL)) u_dut (
        .clk(clk), .rst_n(rst_n), .pci_rst_n(pci_rst_n), .tick(tick),
        .rom_access(rom_access), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_read(logic [1:0] a);
        case (a)
            2'd0: return {2'b0, m_cnt};
            2'd1: return {2'b0, m_rel};
            2'd2: return {5'b0, m_ctrl};
            default: return {5'b0, m_st};
        endcase
    endfunction

    // advance the model by one edge using the inputs as driven
    task automatic model_step(bit pr, bit t, bit w, logic [1:0] a, logic [7:0] d, bit rom);
        logic ld, stp, exp_ev, s1, s2;
        logic [2:0] clr;
        if (!pr) begin
            m_cnt = RST_VAL; m_rel = RST_VAL; m_ctrl = 0; m_st[1:0] = 0; m_seen = 0;
            return;
        end
        ld = w && a == 2'd0;
        clr = (w && a == 2'd3) ? d[2:0] : 3'b0;
        stp = t && !m_ctrl[0] && !ld;
        exp_ev = stp && m_cnt == 0;
        s1 = exp_ev && !m_st[0];
        s2 = exp_ev && m_st[0];
        m_st[2] = (s2 && !m_st[1] && !m_seen) || (m_st[2] && !clr[2]);
        m_st[1] = s2 || (m_st[1] && !clr[1]);
        m_st[0] = s1 || (m_st[0] && !clr[0]);
        if (ld) m_cnt = m_rel;
        else if (stp) m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 1;
        m_seen = m_seen || rom;
        if (w && a == 2'd1) m_rel = d[5:0];
        if (w && a == 2'd2) m_ctrl = d[2:0];
    endtask

    // drive one cycle at the falling edge, then read back after the rising edge
    task automatic step(bit t, bit w, logic [1:0] a, logic [7:0] d, bit rom, bit pr, logic [1:0] ra);
        @(negedge clk);
        tick = t; reg_wr = w; reg_addr = a; reg_wdata = d; rom_access = rom; pci_rst_n = pr;
        model_step(pr, t, w, a, d, rom);
        @(posedge clk);
        #1;
        tick = 0; reg_wr = 0; rom_access = 0; pci_rst_n = 1; reg_addr = ra;
        #0.5;
        case (ra)
            2'd0: chk("R2 count", reg_rdata, model_read(ra));
            2'd1: chk("R3 reload", reg_rdata, model_read(ra));
            2'd2: chk("R7 control", reg_rdata, model_read(ra));
            default: chk("R9 status", reg_rdata, model_read(ra));
        endcase
        chk("R4 irq", {7'b0, irq}, {7'b0, m_st[0] & m_ctrl[2]});
        chk("R6 rst_req", {7'b0, rst_req}, {7'b0, m_st[1] & ~m_ctrl[1]});
    endtask

    task automatic peek(logic [1:0] a, string tag, logic [7:0] exp);
        @(negedge clk);
        reg_wr = 0; reg_addr = a;
        #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_st = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        model_step(0, 0, 0, 0, 0, 0); m_st = 0;
        // R1 reset state
        peek(2'd0, "R1 count", 8'd10);
        peek(2'd1, "R1 reload", 8'd10);
        peek(2'd2, "R1 control", 8'd0);
        peek(2'd3, "R1 status", 8'd0);
        chk("R1 irq", {7'b0, irq}, 8'd0);
        chk("R1 rst_req", {7'b0, rst_req}, 8'd0);

        // R2 single tick
        step(1, 0, 0, 0, 0, 1, 2'd0);
        chk("R2 first decrement", reg_rdata, 8'd9);
        // R3 count write with tick: load wins
        step(0, 1, 2'd1, 8'd2, 0, 1, 2'd1);
        step(0, 1, 2'd2, 8'h04, 0, 1, 2'd2);      // irq enable
        step(1, 1, 2'd0, 8'hA5, 0, 1, 2'd0);
        chk("R3 load beats tick", reg_rdata, 8'd2);
        // R4 first timeout after reload+1 ticks
        step(1, 0, 0, 0, 0, 1, 2'd0);
        step(1, 0, 0, 0, 0, 1, 2'd0);
        step(1, 0, 0, 0, 0, 1, 2'd3);
        chk("R4 first flag", reg_rdata, 8'h01);
        chk("R4 irq high", {7'b0, irq}, 8'd1);
        // R7 halt freezes the count
        step(0, 1, 2'd2, 8'h05, 0, 1, 2'd0);
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 1, 2'd0);
        chk("R7 halted count", reg_rdata, 8'd2);
        step(0, 1, 2'd2, 8'h04, 0, 1, 2'd2);
        // R5 and R8 second timeout without ROM access
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 1, 2'd3);
        chk("R5 R8 second and boot", reg_rdata, 8'h07);
        chk("R6 request", {7'b0, rst_req}, 8'd1);
        step(0, 1, 2'd2, 8'h06, 0, 1, 2'd3);
        chk("R6 no-reboot masks", {7'b0, rst_req}, 8'd0);
        // R10 PCI reset keeps only the boot flag
        step(0, 0, 0, 0, 0, 0, 2'd3);
        chk("R10 boot kept", reg_rdata, 8'h04);
        peek(2'd0, "R10 count restored", 8'd10);
        // R8 ROM fetch before escalation blocks boot failure
        step(0, 1, 2'd3, 8'h04, 0, 1, 2'd3);
        step(0, 1, 2'd1, 8'd0, 1, 1, 2'd1);
        step(0, 1, 2'd0, 8'd0, 0, 1, 2'd0);
        step(1, 0, 0, 0, 0, 1, 2'd3);
        step(1, 0, 0, 0, 0, 1, 2'd3);
        chk("R8 ROM seen no boot", reg_rdata, 8'h03);
        // R9 clear in the same cycle as a first timeout: set wins
        step(0, 1, 2'd3, 8'h03, 0, 1, 2'd3);
        step(1, 1, 2'd3, 8'h01, 0, 1, 2'd3);
        chk("R9 set wins", reg_rdata, 8'h01);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            bit t, w, rom, pr;
            logic [1:0] a;
            logic [7:0] d;
            t = ($urandom % 10) < 6;
            w = ($urandom % 5) == 0;
            a = 2'($urandom % 4);
            d = 8'($urandom);
            if (a == 2'd1) d = 8'($urandom % 6);
            if (a == 2'd2 && ($urandom % 4) != 0) d[0] = 1'b0;
            if (a == 2'd3 && ($urandom % 2) == 0) d = 8'd0;
            rom = ($urandom % 40) == 0;
            pr = ($urandom % 150) != 0;
            step(t, w, a, d, rom, pr, 2'($urandom % 4));
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule